// File: doc/BRIEF.md
# Packed 16-bit Lane Multiplier with Pairwise Multiply-Add

This datapath takes two 64-bit operands, each viewed as four 16-bit lanes, and multiplies lane i of the first operand by lane i of the second to form four 32-bit products. A 2-bit mode picks what the 64-bit result holds. It can hold the low half of every product, the high half read as signed, or the high half read as unsigned. In the fourth mode, adjacent signed products are summed into two 32-bit values.

Software recovers a full 32-bit product by issuing one low-half operation and one high-half operation on the same operands. The multiply-add mode is the building block for dot products and filter taps. The unit has two pipeline stages: the products are registered first, and then the mode selection or the pairwise sum is registered. An operation can be issued on every cycle, and each result appears exactly two cycles after its operation is issued.

Top module: `pmul16x4`

## Requirements
- R1: While `rst_n` is low, `out_valid` is driven low at the next clock edge.
- R2: An operation is accepted on every cycle where `in_valid` is high, with no stall. Each accepted operation gives exactly one result with `out_valid` high two clock edges later, in issue order. If `in_valid` is low, no result appears two edges later.
- R3: In mode 2'b00, result lane i (bits 16i+15..16i) holds bits 15..0 of the product of operand lanes i.
- R4: In mode 2'b01, result lane i holds bits 31..16 of the signed (two's complement) product of operand lanes i.
- R5: In mode 2'b10, result lane i holds bits 31..16 of the unsigned product of operand lanes i.
- R6: In mode 2'b11, bits 31..0 of the result hold the signed product of lane 0 plus the signed product of lane 1. Bits 63..32 hold the signed product of lane 2 plus the signed product of lane 3.
- R7: The multiply-add sum wraps modulo 2^32. With 0x8000 in both operands of two paired lanes, that 32-bit half of the result is 0x80000000.
- R8: The mode 2'b00 result equals the low 16 bits of both the signed and the unsigned product, including for lanes with the top bit set.
- R9: The mode is captured with each operation, so operations with different modes on consecutive cycles each produce the result of their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | 00 low halves, 01 signed high halves, 10 unsigned high halves, 11 pairwise multiply-add |
| op_a | input | 64 | First operand, four 16-bit lanes, lane 0 in bits 15..0 |
| op_b | input | 64 | Second operand, same layout |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| result | output | 64 | Selected result |

## Verification
Fixed vectors are placed in separate lanes: small positive values, negative values, 0xFFFF, 0x7FFF and 0x8000. These show whether the signed and unsigned high halves differ correctly, and they would expose a lane swap. Running the same vectors through the low mode and the unsigned high mode confirms that the low half ignores signedness. Extreme multiply-add pairs exercise the wrapping sum. A long back-to-back stream, where the mode and the operands change on every cycle, checks stall-free acceptance, the two-cycle spacing, and that the right mode is paired with the right operands.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    MODE_LO   = 2'b00,
    MODE_HI_S = 2'b01,
    MODE_HI_U = 2'b10,
    MODE_MADD = 2'b11
  } pmul_mode_e;
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  pmul_pkg::pmul_mode_e mode,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [2*W-1:0]       prod_q
);
  localparam int PW = 2*W;

  // Extend each operand by one bit (zero or sign), multiply signed, keep 2W bits.
  function automatic logic [PW-1:0] lane_product(input logic [W-1:0] x,
                                                 input logic [W-1:0] y,
                                                 input logic         as_unsigned);
    logic signed [W:0]    ex;
    logic signed [W:0]    ey;
    logic signed [PW+1:0] full;
    ex   = $signed({~as_unsigned & x[W-1], x});
    ey   = $signed({~as_unsigned & y[W-1], y});
    full = ex * ey;
    return full[PW-1:0];
  endfunction

  logic [PW-1:0] prod_d;
  assign prod_d = lane_product(a, b, mode == pmul_pkg::MODE_HI_U);

  always_ff @(posedge clk) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end
endmodule

// File: rtl/pmul_combine.sv
module pmul_combine #(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             s1_valid,
  input  pmul_pkg::pmul_mode_e             s1_mode,
  input  logic [LANES-1:0][2*W-1:0]        prods,
  output logic                             out_valid,
  output logic [LANES*W-1:0]               result
);
  localparam int PW    = 2*W;
  localparam int PAIRS = LANES/2;

  function automatic logic [PW-1:0] pair_sum(input logic [PW-1:0] p0,
                                             input logic [PW-1:0] p1);
    return p0 + p1;  // wraps modulo 2^PW
  endfunction

  logic [LANES*W-1:0] lo_word;
  logic [LANES*W-1:0] hi_word;
  logic [LANES*W-1:0] madd_word;
  logic [LANES*W-1:0] sel_word;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign lo_word[i*W +: W] = prods[i][W-1:0];
    assign hi_word[i*W +: W] = prods[i][PW-1:W];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign madd_word[p*PW +: PW] = pair_sum(prods[2*p], prods[2*p+1]);
  end

  always_comb begin
    unique case (s1_mode)
      pmul_pkg::MODE_LO:   sel_word = lo_word;
      pmul_pkg::MODE_MADD: sel_word = madd_word;
      default:             sel_word = hi_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) result <= sel_word;
    end
  end
endmodule

// File: rtl/pmul16x4.sv
module pmul16x4 #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              mode,
  input  logic [LANES*LANE_W-1:0] op_a,
  input  logic [LANES*LANE_W-1:0] op_b,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int PW = 2*LANE_W;

  pmul_pkg::pmul_mode_e      in_mode;
  pmul_pkg::pmul_mode_e      s1_mode;
  logic                      s1_valid;
  logic [LANES-1:0][PW-1:0]  s1_prods;

  assign in_mode = pmul_pkg::pmul_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= pmul_pkg::MODE_LO;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_mode <= in_mode;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .mode   (in_mode),
      .a      (op_a[i*LANE_W +: LANE_W]),
      .b      (op_b[i*LANE_W +: LANE_W]),
      .prod_q (s1_prods[i])
    );
  end

  pmul_combine #(.W(LANE_W), .LANES(LANES)) u_combine (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_mode   (s1_mode),
    .prods     (s1_prods),
    .out_valid (out_valid),
    .result    (result)
  );
endmodule

// File: rtl/pmul16x4_chk.sv
module pmul16x4_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [1:0]     mode,
  input logic [N*W-1:0] op_a,
  input logic [N*W-1:0] op_b,
  input logic           s1_valid,
  input logic           out_valid,
  input logic [N*W-1:0] result
);
  logic [2*W-1:0] u0;
  logic [2*W-1:0] sp0;
  logic [2*W-1:0] sp1;
  logic [2*W-1:0] madd0;
  logic           wrap_case;

  assign u0        = {{W{1'b0}}, op_a[W-1:0]} * {{W{1'b0}}, op_b[W-1:0]};
  assign sp0       = {{W{op_a[W-1]}}, op_a[W-1:0]} * {{W{op_b[W-1]}}, op_b[W-1:0]};
  assign sp1       = {{W{op_a[2*W-1]}}, op_a[2*W-1:W]} * {{W{op_b[2*W-1]}}, op_b[2*W-1:W]};
  assign madd0     = sp0 + sp1;
  assign wrap_case = (op_a[2*W-1:0] == {2{1'b1, {(W-1){1'b0}}}}) &&
                     (op_b[2*W-1:0] == {2{1'b1, {(W-1){1'b0}}}});

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> s1_valid);
  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !s1_valid);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n) s1_valid |=> out_valid);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n) !s1_valid |=> !out_valid);
  assert_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 2'b00) |-> result[W-1:0] == $past(u0[W-1:0], 2));
  assert_high_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 2'b01) |-> result[W-1:0] == $past(sp0[2*W-1:W], 2));
  assert_high_unsigned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 2'b10) |-> result[W-1:0] == $past(u0[2*W-1:W], 2));
  assert_madd_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 2'b11) |-> result[2*W-1:0] == $past(madd0, 2));
  assert_madd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 2'b11 && $past(wrap_case, 2))
      |-> result[2*W-1:0] == {1'b1, {(2*W-1){1'b0}}});
endmodule

bind pmul16x4 pmul16x4_chk #(.W(LANE_W), .N(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/pmul16x4_bench.sv
module pmul16x4_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  pmul16x4 u_pmul16x4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
  );

  // Reference: arithmetic on 32-bit integers, written independently of the RTL
  function automatic logic [31:0] ref_s(input logic [15:0] x, input logic [15:0] y);
    int sx, sy;
    sx = int'($signed(x));
    sy = int'($signed(y));
    return 32'(sx * sy);
  endfunction

  function automatic logic [31:0] ref_u(input logic [15:0] x, input logic [15:0] y);
    longint ux, uy;
    ux = longint'(x);
    uy = longint'(y);
    return 32'(ux * uy);
  endfunction

  function automatic logic [63:0] ref_op(input logic [1:0] m, input logic [63:0] a,
                                         input logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] x, y;
      x = a[16*i +: 16];
      y = b[16*i +: 16];
      case (m)
        2'b00: r[16*i +: 16] = ref_u(x, y) % 32'h10000;
        2'b01: r[16*i +: 16] = ref_s(x, y) >> 16;
        2'b10: r[16*i +: 16] = ref_u(x, y) >> 16;
        default: ;
      endcase
    end
    if (m == 2'b11) begin
      r[31:0]  = ref_s(a[15:0], b[15:0])   + ref_s(a[31:16], b[31:16]);
      r[63:32] = ref_s(a[47:32], b[47:32]) + ref_s(a[63:48], b[63:48]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: inputs change at the falling edge
  task automatic issue(input string tag, input logic [1:0] m, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    mode     = m;
    op_a     = a;
    op_b     = b;
    exp_q.push_back(ref_op(m, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: samples at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R2 unexpected result actual=%h expected=none", result);
      end else begin
        check(tag_q.pop_front(), result, exp_q.pop_front());
      end
    end
  end

  // Spacing check for R2: out_valid must mirror in_valid two edges earlier
  logic [1:0] vpipe = 2'b00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid !== vpipe[1]) begin
        tests++;
        fails++;
        $display("FAIL R2 spacing actual=%b expected=%b", out_valid, vpipe[1]);
      end
    end
  end
  always @(posedge clk) vpipe <= rst_n ? {vpipe[0], in_valid} : 2'b00;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] ra, rb;
    logic [1:0]  rm;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check("R1 idle after reset", {63'd0, out_valid}, 64'd0);

    // R3 / R8: low half, positive and top-bit-set lanes
    issue("R3 low small", 2'b00, 64'h0003_0102_7fff_0005, 64'h0004_0304_0002_0007);
    issue("R8 low negatives", 2'b00, 64'hffff_8000_fffe_8001, 64'hffff_8000_0003_7fff);
    // R4 signed high
    issue("R4 high signed", 2'b01, 64'hffff_8000_7fff_fffe, 64'h0002_8000_7fff_0003);
    issue("R4 high signed mix", 2'b01, 64'h1234_8001_00ff_c000, 64'hfedc_0002_0100_c000);
    // R5 unsigned high, same operands as signed case
    issue("R5 high unsigned", 2'b10, 64'hffff_8000_7fff_fffe, 64'h0002_8000_7fff_0003);
    issue("R5 high unsigned max", 2'b10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_0001_0000);
    // R6 multiply-add
    issue("R6 madd basic", 2'b11, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
    issue("R6 madd signed", 2'b11, 64'hffff_0002_fffd_7fff, 64'h0005_ffff_0004_7fff);
    // R7 wrap
    issue("R7 madd wrap", 2'b11, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    issue("R7 madd wrap mixed", 2'b11, 64'h8000_8000_0001_0001, 64'h8000_8000_ffff_ffff);
    idle(4);

    // R9: same operands, mode changes each cycle
    issue("R9 mode lo", 2'b00, 64'h9abc_8000_1234_ffff, 64'h7fff_8000_5678_fffe);
    issue("R9 mode hs", 2'b01, 64'h9abc_8000_1234_ffff, 64'h7fff_8000_5678_fffe);
    issue("R9 mode hu", 2'b10, 64'h9abc_8000_1234_ffff, 64'h7fff_8000_5678_fffe);
    issue("R9 mode madd", 2'b11, 64'h9abc_8000_1234_ffff, 64'h7fff_8000_5678_fffe);
    idle(1);
    issue("R2 after gap", 2'b01, 64'h0001_0001_0001_0001, 64'hffff_ffff_ffff_ffff);
    idle(3);

    // R2 / R9: long back-to-back stream
    for (int k = 0; k < 300; k++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rm = 2'($urandom);
      issue("R2 R9 stream", rm, ra, rb);
      if (k % 37 == 36) idle(2);
    end
    idle(5);

    check("R2 all results returned", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule